// File: doc/BRIEF.md
# Register-Programmed Single-Channel Memory Copy Engine

The block copies a run of bytes from one region of memory to another. Software programs a source address, a destination address, a byte count and a separate access description for each side, then writes a start bit. The engine reads the source one beat at a time. It gathers the bytes in a four-byte staging word and writes them out in beats of the destination width. Because of this, a stream of 16-bit reads can be packed into 32-bit writes, and a stream of 32-bit reads can be split into 16-bit writes.

When the copy completes, a sticky done flag is set. When a request is rejected, a sticky error flag is set instead. Software clears each flag with its own command bit. Both flags are also reflected into an interrupt unit. That unit holds a raw status view, latched pending bits that software clears by writing ones, and a mask that gates the interrupt line. The memories sit outside the block behind a simple read port and a simple write port. Read data returns one cycle after the request.

Top module: `bdma_engine`

## Requirements
- R1: After reset, the status word (0x41C), the interrupt pending (0x1044) and status (0x1064) words, and every configuration register read as zero. The irq output is low, and no memory request is raised.
- R2: These registers read back the value last written: source address 0x400, source access 0x404, destination address 0x408, destination access 0x40C, byte count 0x414 and direction 0x420. An access word keeps only bits [18:16] (burst code), bit 8 (fixed address) and bits [1:0] (width code), and direction keeps only bit 0.
- R3: Writing bit 0 of the command word (0x418) with a legal setup starts the copy. Status bit 17 (busy) is then 1 until the last destination beat has been written. After that, bit 17 returns to 0 and bit 18 (done) is 1. The destination receives exactly the byte count, in address order.
- R4: Width codes 0, 1 and 2 mean 1-, 2- and 4-byte beats. Bytes are packed and unpacked little-endian: the first source byte lands in the lowest byte lane of the first destination beat.
- R5: With access bit 8 at 0, a side's address advances by its beat size after each beat. With bit 8 at 1, the address stays at its base for the whole copy.
- R6: A start with width code 3, or with a burst code other than 0, 2, 3 or 4, on either side sets status bit 16 (error) one cycle after the write. No memory access is made.
- R7: A start with a byte count of zero, or with a count that is not a multiple of the larger of the two beat sizes, sets the error bit. No memory access is made.
- R8: Command bit 16 clears the error flag and command bit 18 clears the done flag. Each clears only its own flag.
- R9: A start written while busy is ignored. The running copy completes unchanged, and no second copy follows.
- R10: The interrupt status word (0x1064) shows done at bit 24 and error at bit 16. A flag being set latches the matching pending bit (0x1044). Writing a 1 to that bit of 0x1004 clears it. A 1 in the mask word (0x1024) blocks that bit. irq is high whenever a pending bit is set and its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rd_req | output | 1 | Source read request |
| rd_addr | output | 32 | Source byte address |
| rd_size | output | 2 | Source width code |
| rd_data | input | 32 | Read data, valid the cycle after rd_req |
| wr_req | output | 1 | Destination write request |
| wr_addr | output | 32 | Destination byte address |
| wr_size | output | 2 | Destination width code |
| wr_data | output | 32 | Write data, valid bytes in the low lanes |
| irq | output | 1 | Unmasked pending interrupt |

## Verification
Every register write takes effect at the clock edge after the strobe. A rejected start therefore shows the error bit, its pending bit and irq one cycle after the command, and the bench reads these right after the write. Each source beat costs two cycles (the request, then the data return), and each destination beat costs one cycle. The done flag appears in the cycle after the final write beat. Because this latency depends on the setup, the bench polls the busy bit with a bound rather than counting cycles. The write stream is compared beat by beat on the falling edge of the cycle that carries wr_req. The comparison uses a queue of beats predicted from the bench's own memory copy before each start, so a write that arrives out of order, is missing, or should not happen is reported immediately.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
    localparam int REG_AW = 13;
    localparam int DATA_W = 32;

    localparam logic [REG_AW-1:0] OFF_SRC_ADDR = 13'h400;
    localparam logic [REG_AW-1:0] OFF_SRC_CFG  = 13'h404;
    localparam logic [REG_AW-1:0] OFF_DST_ADDR = 13'h408;
    localparam logic [REG_AW-1:0] OFF_DST_CFG  = 13'h40C;
    localparam logic [REG_AW-1:0] OFF_SIZE     = 13'h414;
    localparam logic [REG_AW-1:0] OFF_CMD      = 13'h418;
    localparam logic [REG_AW-1:0] OFF_STAT     = 13'h41C;
    localparam logic [REG_AW-1:0] OFF_DIR      = 13'h420;
    localparam logic [REG_AW-1:0] OFF_IRQ_CLR  = 13'h1004;
    localparam logic [REG_AW-1:0] OFF_IRQ_MASK = 13'h1024;
    localparam logic [REG_AW-1:0] OFF_IRQ_PEND = 13'h1044;
    localparam logic [REG_AW-1:0] OFF_IRQ_STAT = 13'h1064;

    localparam int CMD_GO       = 0;
    localparam int CMD_CLR_ERR  = 16;
    localparam int CMD_CLR_DONE = 18;
    localparam int IRQ_BIT_ERR  = 16;
    localparam int IRQ_BIT_DONE = 24;

    typedef struct packed {
        logic [2:0] burst;
        logic       fixed;
        logic [1:0] width;
    } side_cfg_t;

    typedef enum logic [1:0] {MV_IDLE, MV_ISSUE, MV_WAIT} mv_state_e;

    function automatic logic [2:0] beat_bytes(input logic [1:0] w);
        return 3'd1 << w;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] w);
        case (w)
            2'd0:    return DATA_W'(32'h0000_00FF);
            2'd1:    return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    function automatic logic cfg_legal(input side_cfg_t c);
        return (c.width != 2'd3) &&
               (c.burst == 3'd0 || c.burst == 3'd2 || c.burst == 3'd3 || c.burst == 3'd4);
    endfunction

    function automatic logic [31:0] cfg_to_word(input side_cfg_t c);
        return {13'b0, c.burst, 7'b0, c.fixed, 6'b0, c.width};
    endfunction
endpackage

// File: rtl/bdma_regfile.sv
module bdma_regfile
    import bdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output side_cfg_t         src_cfg,
    output side_cfg_t         dst_cfg,
    output logic [SIZE_W-1:0] xfer_size,
    output logic              dir_bit,
    output logic              go,
    output logic              clr_err,
    output logic              clr_done
);
    typedef struct packed {
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] da;
        side_cfg_t         sc;
        side_cfg_t         dc;
        logic [SIZE_W-1:0] size;
        logic              dir;
    } rf_t;

    rf_t rf_d, rf_q;
    side_cfg_t w_cfg;

    always_comb begin
        w_cfg = '{burst: reg_wdata[18:16], fixed: reg_wdata[8], width: reg_wdata[1:0]};
        rf_d  = rf_q;
        if (reg_wr) begin
            case (reg_addr)
                OFF_SRC_ADDR: rf_d.sa   = reg_wdata[ADDR_W-1:0];
                OFF_DST_ADDR: rf_d.da   = reg_wdata[ADDR_W-1:0];
                OFF_SRC_CFG:  rf_d.sc   = w_cfg;
                OFF_DST_CFG:  rf_d.dc   = w_cfg;
                OFF_SIZE:     rf_d.size = reg_wdata[SIZE_W-1:0];
                OFF_DIR:      rf_d.dir  = reg_wdata[0];
                default: ;
            endcase
        end
        go       = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[CMD_GO];
        clr_err  = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[CMD_CLR_ERR];
        clr_done = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[CMD_CLR_DONE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign src_base  = rf_q.sa;
    assign dst_base  = rf_q.da;
    assign src_cfg   = rf_q.sc;
    assign dst_cfg   = rf_q.dc;
    assign xfer_size = rf_q.size;
    assign dir_bit   = rf_q.dir;
endmodule

// File: rtl/bdma_mover.sv
module bdma_mover
    import bdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              clr_done,
    input  logic              clr_err,
    input  side_cfg_t         src_cfg,
    input  side_cfg_t         dst_cfg,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [SIZE_W-1:0] xfer_size,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              done_set,
    output logic              err_set,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        mv_state_e         st;
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] da;
        logic [SIZE_W-1:0] left;
        logic [DATA_W-1:0] stage;
        logic [2:0]        fill;
        side_cfg_t         sc;
        side_cfg_t         dc;
        logic              done;
        logic              err;
    } mv_t;

    mv_t mv_d, mv_q;
    logic [2:0] sb, db, nsb, ndb, nmax;
    logic       start_ok;

    always_comb begin
        nsb      = beat_bytes(src_cfg.width);
        ndb      = beat_bytes(dst_cfg.width);
        nmax     = (nsb > ndb) ? nsb : ndb;
        start_ok = cfg_legal(src_cfg) && cfg_legal(dst_cfg) && (xfer_size != '0) &&
                   ((xfer_size[2:0] & (nmax - 3'd1)) == 3'd0);
        sb       = beat_bytes(mv_q.sc.width);
        db       = beat_bytes(mv_q.dc.width);
        mv_d     = mv_q;
        done_set = 1'b0;
        err_set  = 1'b0;
        rd_req   = 1'b0;
        wr_req   = 1'b0;
        if (clr_done) mv_d.done = 1'b0;
        if (clr_err)  mv_d.err  = 1'b0;
        unique case (mv_q.st)
            MV_IDLE: begin
                if (go) begin
                    if (start_ok) begin
                        mv_d.st    = MV_ISSUE;
                        mv_d.sa    = src_base;
                        mv_d.da    = dst_base;
                        mv_d.left  = xfer_size;
                        mv_d.stage = '0;
                        mv_d.fill  = 3'd0;
                        mv_d.sc    = src_cfg;
                        mv_d.dc    = dst_cfg;
                    end else begin
                        mv_d.err = 1'b1;
                        err_set  = 1'b1;
                    end
                end
            end
            MV_ISSUE: begin
                if (mv_q.fill < db) begin
                    rd_req  = 1'b1;
                    mv_d.st = MV_WAIT;
                end else begin
                    wr_req     = 1'b1;
                    mv_d.stage = mv_q.stage >> {db, 3'b000};
                    mv_d.fill  = mv_q.fill - db;
                    mv_d.left  = mv_q.left - SIZE_W'(db);
                    if (!mv_q.dc.fixed) mv_d.da = mv_q.da + ADDR_W'(db);
                    if (mv_q.left == SIZE_W'(db)) begin
                        mv_d.st   = MV_IDLE;
                        mv_d.done = 1'b1;
                        done_set  = 1'b1;
                    end
                end
            end
            MV_WAIT: begin
                mv_d.stage = mv_q.stage |
                             ((rd_data & lane_mask(mv_q.sc.width)) << {mv_q.fill, 3'b000});
                mv_d.fill  = mv_q.fill + sb;
                if (!mv_q.sc.fixed) mv_d.sa = mv_q.sa + ADDR_W'(sb);
                mv_d.st    = MV_ISSUE;
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mv_q <= '{st: MV_IDLE, default: '0};
        else        mv_q <= mv_d;
    end

    assign busy    = (mv_q.st != MV_IDLE);
    assign done    = mv_q.done;
    assign err     = mv_q.err;
    assign rd_addr = mv_q.sa;
    assign rd_size = mv_q.sc.width;
    assign wr_addr = mv_q.da;
    assign wr_size = mv_q.dc.width;
    assign wr_data = mv_q.stage;
endmodule

// File: rtl/bdma_irq.sv
module bdma_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_set,
    input  logic       err_set,
    input  logic       clr_wr,
    input  logic       mask_wr,
    input  logic [1:0] wbits,
    output logic [1:0] pend,
    output logic [1:0] mask,
    output logic       irq
);
    typedef struct packed {
        logic [1:0] pend;
        logic [1:0] mask;
    } irq_t;

    irq_t ir_d, ir_q;

    always_comb begin
        ir_d      = ir_q;
        ir_d.pend = (ir_q.pend & ~(clr_wr ? wbits : 2'b00)) | {done_set, err_set};
        if (mask_wr) ir_d.mask = wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    assign pend = ir_q.pend;
    assign mask = ir_q.mask;
    assign irq  = |(ir_q.pend & ~ir_q.mask);
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
    import bdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    logic [ADDR_W-1:0] src_base, dst_base;
    side_cfg_t         src_cfg, dst_cfg;
    logic [SIZE_W-1:0] xfer_size;
    logic              dir_bit, go, clr_err, clr_done;
    logic              mv_busy, mv_done, mv_err, mv_done_set, mv_err_set;
    logic [1:0]        irq_pend, irq_mask;
    logic              irq_clr_wr, irq_mask_wr;

    assign irq_clr_wr  = reg_wr && (reg_addr == OFF_IRQ_CLR);
    assign irq_mask_wr = reg_wr && (reg_addr == OFF_IRQ_MASK);

    bdma_regfile #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .src_base(src_base), .dst_base(dst_base),
        .src_cfg(src_cfg), .dst_cfg(dst_cfg), .xfer_size(xfer_size),
        .dir_bit(dir_bit), .go(go), .clr_err(clr_err), .clr_done(clr_done)
    );

    bdma_mover #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .go(go), .clr_done(clr_done), .clr_err(clr_err),
        .src_cfg(src_cfg), .dst_cfg(dst_cfg), .src_base(src_base), .dst_base(dst_base),
        .xfer_size(xfer_size), .busy(mv_busy), .done(mv_done), .err(mv_err),
        .done_set(mv_done_set), .err_set(mv_err_set),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data)
    );

    bdma_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done_set(mv_done_set), .err_set(mv_err_set),
        .clr_wr(irq_clr_wr), .mask_wr(irq_mask_wr),
        .wbits({reg_wdata[IRQ_BIT_DONE], reg_wdata[IRQ_BIT_ERR]}),
        .pend(irq_pend), .mask(irq_mask), .irq(irq)
    );

    function automatic logic [31:0] irq_word(input logic [1:0] b);
        return {7'b0, b[1], 7'b0, b[0], 16'b0};
    endfunction

    always_comb begin
        case (reg_addr)
            OFF_SRC_ADDR: reg_rdata = 32'(src_base);
            OFF_DST_ADDR: reg_rdata = 32'(dst_base);
            OFF_SRC_CFG:  reg_rdata = cfg_to_word(src_cfg);
            OFF_DST_CFG:  reg_rdata = cfg_to_word(dst_cfg);
            OFF_SIZE:     reg_rdata = 32'(xfer_size);
            OFF_DIR:      reg_rdata = {31'b0, dir_bit};
            OFF_STAT:     reg_rdata = {13'b0, mv_done, mv_busy, mv_err, 16'b0};
            OFF_IRQ_MASK: reg_rdata = irq_word(irq_mask);
            OFF_IRQ_PEND: reg_rdata = irq_word(irq_pend);
            OFF_IRQ_STAT: reg_rdata = irq_word({mv_done, mv_err});
            default:      reg_rdata = 32'b0;
        endcase
    end
endmodule

// File: rtl/bdma_engine_chk.sv
module bdma_engine_chk
    import bdma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              done_set,
    input logic              rd_req,
    input logic              wr_req,
    input logic              pend_done
);
    // R7
    no_mem_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(rd_req || wr_req));

    // R3
    one_access_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R3
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    err_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(reg_wr && reg_addr == OFF_CMD && reg_wdata[CMD_GO]));

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_IRQ_CLR && reg_wdata[IRQ_BIT_DONE] && !done_set)
        |=> !pend_done);
endmodule

bind bdma_engine bdma_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(mv_busy), .done(mv_done), .err(mv_err),
    .done_set(mv_done_set), .rd_req(rd_req), .wr_req(wr_req),
    .pend_done(irq_pend[1])
);

// File: tb/bdma_engine_tb_top.sv
`timescale 1ns/100ps
module bdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_req, wr_req, irq;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [31:0] rd_data = '0;
    logic [1:0]  rd_size, wr_size;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] a;
        logic [1:0]  s;
        logic [31:0] d;
    } beat_t;
    beat_t exp_q[$];

    logic [7:0] mem [0:1023];

    always #2.5 clk = ~clk;

    bdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .irq(irq)
    );

    // behavioural memory: read data one cycle after request, byte writes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'((i * 7 + 3) ^ (i >> 3));
        end else begin
            if (rd_req)
                rd_data <= {mem[(rd_addr + 3) & 1023], mem[(rd_addr + 2) & 1023],
                            mem[(rd_addr + 1) & 1023], mem[rd_addr & 1023]};
            if (wr_req)
                for (int b = 0; b < (1 << wr_size); b++)
                    mem[(wr_addr + b) & 1023] <= wr_data[8*b +: 8];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_req) begin
            beat_t e;
            logic [31:0] m;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R3/R7 unexpected write addr=%h data=%h expected none", wr_addr, wr_data);
            end else begin
                e = exp_q.pop_front();
                m = (e.s == 2'd0) ? 32'hFF : (e.s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
                if (wr_addr != e.a || wr_size != e.s || (wr_data & m) != e.d) begin
                    failures++;
                    $display("FAIL R4/R5 write beat actual a=%h s=%0d d=%h expected a=%h s=%0d d=%h",
                             wr_addr, wr_size, wr_data & m, e.a, e.s, e.d);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wreg(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfgw(input int burst, input bit fix, input int w);
        return (32'(burst) << 16) | (32'(fix) << 8) | 32'(w);
    endfunction

    // driver: program, push expected beats, start
    task automatic run_copy(input int sa, input int sw, input bit sfix,
                            input int da, input int dw, input bit dfix, input int size);
        int sb, db;
        sb = 1 << sw; db = 1 << dw;
        for (int k = 0; k < size / db; k++) begin
            beat_t e;
            e.d = '0;
            for (int b = 0; b < db; b++) begin
                int i, off;
                i = k * db + b;
                off = sfix ? (i % sb) : i;
                e.d[8*b +: 8] = mem[(sa + off) & 1023];
            end
            e.a = dfix ? 32'(da) : 32'(da + k * db);
            e.s = 2'(dw);
            exp_q.push_back(e);
        end
        wreg(13'h400, 32'(sa));
        wreg(13'h404, cfgw(4, sfix, sw));
        wreg(13'h408, 32'(da));
        wreg(13'h40C, cfgw(4, dfix, dw));
        wreg(13'h414, 32'(size));
        wreg(13'h418, 32'h1);
    endtask

    task automatic wait_idle(output logic [31:0] st);
        for (int n = 0; n < 2000; n++) begin
            rreg(13'h41C, st);
            if (!st[17]) break;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] v, st;
        logic [7:0]  keep;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rreg(13'h41C, v);  chk("R1 status", v, 32'h0);
        rreg(13'h1044, v); chk("R1 pending", v, 32'h0);
        rreg(13'h1064, v); chk("R1 irq status", v, 32'h0);
        rreg(13'h404, v);  chk("R1 src cfg", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 no request", {30'b0, rd_req, wr_req}, 32'h0);

        // R2 readback and field masking
        wreg(13'h400, 32'h0000_0123); rreg(13'h400, v); chk("R2 src addr", v, 32'h0000_0123);
        wreg(13'h408, 32'hDEAD_BEE0); rreg(13'h408, v); chk("R2 dst addr", v, 32'hDEAD_BEE0);
        wreg(13'h404, 32'hFFFF_FFFF); rreg(13'h404, v); chk("R2 src cfg mask", v, 32'h0007_0103);
        wreg(13'h40C, 32'h0003_0001); rreg(13'h40C, v); chk("R2 dst cfg", v, 32'h0003_0001);
        wreg(13'h414, 32'h0000_0040); rreg(13'h414, v); chk("R2 size", v, 32'h0000_0040);
        wreg(13'h420, 32'hFFFF_FFFF); rreg(13'h420, v); chk("R2 direction", v, 32'h1);

        // R3 R4 16-bit reads packed into 32-bit writes
        run_copy(32'h000, 1, 0, 32'h200, 2, 0, 16);
        rreg(13'h41C, v); chk("R3 busy after start", v & 32'h0002_0000, 32'h0002_0000);
        wait_idle(st);
        chk("R3 done not busy", st, 32'h0004_0000);
        chk("R3 all beats seen", 32'(exp_q.size()), 32'h0);
        chk("R3 dest byte", {24'b0, mem[32'h20F]}, {24'b0, mem[32'h00F]});
        rreg(13'h1064, v); chk("R10 irq status done", v, 32'h0100_0000);
        rreg(13'h1044, v); chk("R10 pending done", v, 32'h0100_0000);
        chk("R10 irq high", {31'b0, irq}, 32'h1);

        // R8 clear done only; R10 clear pending
        wreg(13'h418, 32'h0004_0000); rreg(13'h41C, v); chk("R8 done cleared", v, 32'h0);
        wreg(13'h1004, 32'h0100_0000); rreg(13'h1044, v); chk("R10 pending cleared", v, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);

        // R4 32-bit reads split into 16-bit writes
        run_copy(32'h040, 2, 0, 32'h240, 1, 0, 12);
        wait_idle(st);
        chk("R4 unpack done", st, 32'h0004_0000);
        chk("R4 unpack beats", 32'(exp_q.size()), 32'h0);

        // R5 fixed source address, then fixed destination address
        run_copy(32'h080, 1, 1, 32'h280, 2, 0, 8);
        wait_idle(st);
        chk("R5 fixed src beats", 32'(exp_q.size()), 32'h0);
        run_copy(32'h0C0, 0, 0, 32'h2C0, 0, 1, 4);
        wait_idle(st);
        chk("R5 fixed dst beats", 32'(exp_q.size()), 32'h0);
        wreg(13'h418, 32'h0004_0000);
        wreg(13'h1004, 32'h0101_0000);

        // R6 illegal width code
        keep = mem[32'h300];
        wreg(13'h404, 32'h0004_0003);
        wreg(13'h40C, 32'h0004_0002);
        wreg(13'h408, 32'h300);
        wreg(13'h414, 32'd8);
        wreg(13'h418, 32'h1);
        rreg(13'h41C, v); chk("R6 width error", v, 32'h0001_0000);
        rreg(13'h1044, v); chk("R10 pending error", v, 32'h0001_0000);
        chk("R10 irq on error", {31'b0, irq}, 32'h1);
        wreg(13'h1024, 32'h0001_0000);
        chk("R10 masked irq low", {31'b0, irq}, 32'h0);
        rreg(13'h1044, v); chk("R10 pending kept while masked", v, 32'h0001_0000);
        wreg(13'h418, 32'h0001_0000); rreg(13'h41C, v); chk("R8 error cleared", v, 32'h0);
        wreg(13'h1004, 32'h0001_0000);
        wreg(13'h1024, 32'h0);

        // R6 illegal burst code
        wreg(13'h404, 32'h0001_0001);
        wreg(13'h418, 32'h1);
        rreg(13'h41C, v); chk("R6 burst error", v, 32'h0001_0000);
        wreg(13'h418, 32'h0001_0000);

        // R7 zero size and misaligned size
        wreg(13'h404, 32'h0004_0001);
        wreg(13'h414, 32'd0);
        wreg(13'h418, 32'h1);
        rreg(13'h41C, v); chk("R7 zero size error", v, 32'h0001_0000);
        wreg(13'h418, 32'h0001_0000);
        wreg(13'h414, 32'd6);
        wreg(13'h418, 32'h1);
        rreg(13'h41C, v); chk("R7 misaligned error", v, 32'h0001_0000);
        repeat (3) @(negedge clk);
        chk("R7 no data moved", {24'b0, mem[32'h300]}, {24'b0, keep});
        wreg(13'h418, 32'h0001_0000);
        wreg(13'h1004, 32'h0101_0000);

        // R9 start while busy is ignored
        run_copy(32'h100, 0, 0, 32'h340, 0, 0, 32);
        wreg(13'h400, 32'h180);
        wreg(13'h418, 32'h1);
        rreg(13'h41C, v); chk("R9 still busy, no error", v & 32'h0003_0000, 32'h0002_0000);
        wait_idle(st);
        repeat (20) @(negedge clk);
        rreg(13'h41C, v); chk("R9 single copy finished", v, 32'h0004_0000);
        chk("R9 beats", 32'(exp_q.size()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule